// File: doc/BRIEF.md
# Opcode-Menu SPI Command Sequencer

This block is a register-programmed SPI flash master. Software never hands it a raw opcode. It loads eight opcode bytes into a menu, gives each entry a 2-bit type, and then starts a cycle by naming a menu index in the control word. The type of the selected entry decides two things: whether a 24-bit address follows the opcode, and whether the optional data phase drives bytes out of the data buffer or captures bytes into it.

A cycle can optionally be preceded by one of two stored prefix opcodes, typically a write-enable. The prefix goes out in its own chip-select frame. Chip select then stays high for a guaranteed gap before the main command frame, and no other traffic can be placed between the two frames.

The serial side is single-bit SPI mode 0. The host side is a word-wide write/read register port with a combinational read path.

Top module: `spi_menu_seq`

Register word addresses (`reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | control | Cycle start and per-cycle settings (see R2, R4, R5, R10). |
| 1 | status | Busy, done and error flags (see R8). |
| 2 | flash address | 24 bits (see R3). |
| 3 | prefix | Two prefix opcodes. |
| 4 | type | 2-bit type for each menu entry. |
| 5 | menu low | Entries 0 to 3, entry n at bits 8n+7:8n. |
| 6 | menu high | Entries 4 to 7, entry 4+n at bits 8n+7:8n. |
| Top address bit set | data buffer | Low address bits select the data word. |

## Requirements
- R1: After reset, every register reads 0, the data buffer reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Writing the control register with bit 1 set while idle starts a cycle. The first byte of the main frame is menu entry `ctl[6:4]`. The entry's type is `type[2i+1:2i]`, with 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address.
- R3: For types 2 and 3, three address bytes follow the opcode, most significant byte first. Bits 31:24 of the address register are not stored and read back as 0.
- R4: When `ctl[14]` is set, the data phase carries `ctl[8 +: log2(BUF_BYTES)] + 1` bytes. Write types send buffer bytes starting at byte 0. Read types store the received bytes into the buffer starting at byte 0 and leave the higher bytes unchanged. Buffer byte i sits in data word i/4 at bits 8*(i%4)+7:8*(i%4).
- R5: When `ctl[3]` is set, a one-byte prefix frame precedes the main frame. `ctl[2]` = 1 picks `prefix[15:8]`, and `ctl[2]` = 0 picks `prefix[7:0]`.
- R6: Between the prefix frame and the main frame, `spi_cs_n` stays high for at least two SCLK periods (2*CS_GAP*SCK_HALF clock cycles).
- R7: Mode 0 with MSB first. `spi_sclk` is low whenever `spi_cs_n` changes. `spi_mosi` holds steady while `spi_sclk` is high. `spi_miso` is sampled on the rising edge of `spi_sclk`.
- R8: Status bit 0 (busy) is 1 from the start write until the frame ends, and it is read-only. Status bit 1 (done) is set as busy falls. Writing 1 to status bit 1 clears done, and writing 1 to status bit 2 clears the error flag.
- R9: A start request while busy is ignored and sets status bit 2 (error). While busy, writes to control, address, prefix, type, menu and buffer have no effect.
- R10: When `ctl[14]` is clear, the main frame carries only the opcode plus, for types 2 and 3, the address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from `reg_addr`) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with `BUF_BYTES` = 16, `SCK_HALF` = 1 and `CS_GAP` = 2. This makes the byte-count field four bits wide, so every data length from 1 to 16 can be swept in both directions, including the full-buffer case. Each cycle is short enough that all eight menu entries can be crossed with all four types, all three prefix choices and both settings of the data-phase bit. The 4-cycle inter-frame gap is small enough that its exact length can be measured against the two-SCLK-period bound.

// File: rtl/spi_menu_seq.sv
module spi_menu_seq #(
  parameter  int BUF_BYTES = 64,
  parameter  int SCK_HALF  = 2,
  parameter  int CS_GAP    = 2,
  localparam int WIDX      = $clog2(BUF_BYTES / 4),
  localparam int AW        = (WIDX > 3 ? WIDX : 3) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int CNT_W   = $clog2(BUF_BYTES);
  localparam int GAP_CYC = 2 * CS_GAP * SCK_HALF;
  localparam int DW      = $clog2(SCK_HALF + 1);
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_STS = AW'(1);
  localparam logic [AW-1:0] A_ADR = AW'(2);
  localparam logic [AW-1:0] A_PFX = AW'(3);
  localparam logic [AW-1:0] A_TYP = AW'(4);
  localparam logic [AW-1:0] A_MLO = AW'(5);
  localparam logic [AW-1:0] A_MHI = AW'(6);

  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_GAP, PH_OPC, PH_ADR, PH_DAT} phase_t;

  phase_t           ph_q;
  logic [15:0]      ctl_q, pfx_q, typ_q;
  logic [23:0]      adr_q;
  logic [63:0]      menu_q;
  logic [7:0]       buf_q [BUF_BYTES];
  logic             busy_q, done_q, err_q;
  logic             sclk_q, cs_n_q;
  logic [7:0]       tx_q, rx_q;
  logic [2:0]       bit_n;
  logic [CNT_W-1:0] byte_n;
  logic [DW-1:0]    div_q;
  logic [GW-1:0]    gap_q;

  logic [WIDX-1:0]  dw;
  logic [2:0]       cur_idx;
  logic [1:0]       cur_typ;
  logic             has_adr, is_wr, den, tick, byte_end, host_dwr, rx_store;
  logic [CNT_W-1:0] cur_cnt, nxt_byte;

  assign dw       = reg_addr[WIDX-1:0];
  assign cur_idx  = ctl_q[6:4];
  assign cur_typ  = typ_q[{cur_idx, 1'b0} +: 2];
  assign has_adr  = cur_typ[1];
  assign is_wr    = cur_typ[0];
  assign den      = ctl_q[14];
  assign cur_cnt  = ctl_q[8 +: CNT_W];
  assign nxt_byte = byte_n + 1'b1;
  assign tick     = (div_q == DW'(SCK_HALF - 1));
  assign byte_end = busy_q && ph_q != PH_IDLE && ph_q != PH_GAP && tick && sclk_q && bit_n == 3'd7;
  assign host_dwr = reg_we && !busy_q && reg_addr[AW-1];
  assign rx_store = byte_end && ph_q == PH_DAT && !is_wr;

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign spi_mosi = tx_q[7];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1])
      reg_rdata = {buf_q[{dw, 2'd3}], buf_q[{dw, 2'd2}], buf_q[{dw, 2'd1}], buf_q[{dw, 2'd0}]};
    else
      case (reg_addr)
        A_CTL:   reg_rdata = {16'h0, ctl_q};
        A_STS:   reg_rdata = {29'h0, err_q, done_q, busy_q};
        A_ADR:   reg_rdata = {8'h0, adr_q};
        A_PFX:   reg_rdata = {16'h0, pfx_q};
        A_TYP:   reg_rdata = {16'h0, typ_q};
        A_MLO:   reg_rdata = menu_q[31:0];
        A_MHI:   reg_rdata = menu_q[63:32];
        default: reg_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else if (host_dwr) begin
      buf_q[{dw, 2'd0}] <= reg_wdata[7:0];
      buf_q[{dw, 2'd1}] <= reg_wdata[15:8];
      buf_q[{dw, 2'd2}] <= reg_wdata[23:16];
      buf_q[{dw, 2'd3}] <= reg_wdata[31:24];
    end else if (rx_store) begin
      buf_q[byte_n] <= rx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ctl_q  <= '0;
      pfx_q  <= '0;
      typ_q  <= '0;
      adr_q  <= '0;
      menu_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_n  <= '0;
      byte_n <= '0;
      div_q  <= '0;
      gap_q  <= '0;
    end else begin
      if (reg_we && reg_addr == A_STS) begin
        if (reg_wdata[1]) done_q <= 1'b0;
        if (reg_wdata[2]) err_q  <= 1'b0;
      end
      if (reg_we && busy_q && reg_addr == A_CTL && reg_wdata[1]) err_q <= 1'b1;

      if (reg_we && !busy_q) begin
        case (reg_addr)
          A_CTL: begin
            ctl_q <= reg_wdata[15:0] & 16'hFFFD;
            if (reg_wdata[1]) begin
              busy_q <= 1'b1;
              cs_n_q <= 1'b0;
              sclk_q <= 1'b0;
              div_q  <= '0;
              bit_n  <= '0;
              byte_n <= '0;
              if (reg_wdata[3]) begin
                ph_q <= PH_PRE;
                tx_q <= reg_wdata[2] ? pfx_q[15:8] : pfx_q[7:0];
              end else begin
                ph_q <= PH_OPC;
                tx_q <= menu_q[{reg_wdata[6:4], 3'b000} +: 8];
              end
            end
          end
          A_ADR:   adr_q  <= reg_wdata[23:0];
          A_PFX:   pfx_q  <= reg_wdata[15:0];
          A_TYP:   typ_q  <= reg_wdata[15:0];
          A_MLO:   menu_q[31:0]  <= reg_wdata;
          A_MHI:   menu_q[63:32] <= reg_wdata;
          default: ;
        endcase
      end

      if (ph_q == PH_GAP) begin
        if (gap_q == GW'(GAP_CYC - 1)) begin
          ph_q   <= PH_OPC;
          cs_n_q <= 1'b0;
          tx_q   <= menu_q[{cur_idx, 3'b000} +: 8];
          div_q  <= '0;
          bit_n  <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end else if (ph_q != PH_IDLE) begin
        if (!tick) begin
          div_q <= div_q + 1'b1;
        end else begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], spi_miso};
          end else begin
            sclk_q <= 1'b0;
            bit_n  <= bit_n + 1'b1;
            if (bit_n != 3'd7) begin
              tx_q <= {tx_q[6:0], 1'b0};
            end else begin
              case (ph_q)
                PH_PRE: begin
                  ph_q   <= PH_GAP;
                  cs_n_q <= 1'b1;
                  gap_q  <= '0;
                end
                PH_OPC: begin
                  byte_n <= '0;
                  if (has_adr) begin
                    ph_q <= PH_ADR;
                    tx_q <= adr_q[23:16];
                  end else if (den) begin
                    ph_q <= PH_DAT;
                    tx_q <= is_wr ? buf_q[0] : 8'h00;
                  end else begin
                    ph_q   <= PH_IDLE;
                    cs_n_q <= 1'b1;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                  end
                end
                PH_ADR: begin
                  if (byte_n != CNT_W'(2)) begin
                    byte_n <= nxt_byte;
                    tx_q   <= (byte_n == '0) ? adr_q[15:8] : adr_q[7:0];
                  end else if (den) begin
                    byte_n <= '0;
                    ph_q   <= PH_DAT;
                    tx_q   <= is_wr ? buf_q[0] : 8'h00;
                  end else begin
                    ph_q   <= PH_IDLE;
                    cs_n_q <= 1'b1;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                  end
                end
                PH_DAT: begin
                  if (byte_n == cur_cnt) begin
                    ph_q   <= PH_IDLE;
                    cs_n_q <= 1'b1;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                  end else begin
                    byte_n <= nxt_byte;
                    tx_q   <= is_wr ? buf_q[nxt_byte] : 8'h00;
                  end
                end
                default: ph_q <= PH_IDLE;
              endcase
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_menu_seq_chk.sv
module spi_menu_seq_chk #(
  parameter  int BUF_BYTES = 64,
  parameter  int SCK_HALF  = 2,
  parameter  int CS_GAP    = 2,
  localparam int WIDX      = $clog2(BUF_BYTES / 4),
  localparam int AW        = (WIDX > 3 ? WIDX : 3) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          spi_sclk,
  input logic          spi_cs_n,
  input logic          spi_mosi,
  input logic          busy_q,
  input logic          done_q,
  input logic          err_q
);
  localparam int GAP_CYC = 2 * CS_GAP * SCK_HALF;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R8
  idle_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> spi_cs_n);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy_q));

  // R9
  busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we && reg_addr == AW'(0) && reg_wdata[1]) |=> err_q);

  // R6
  prefix_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && busy_q && $past(busy_q)) |-> (hi_cnt >= 16'(GAP_CYC)));
endmodule

bind spi_menu_seq spi_menu_seq_chk #(
  .BUF_BYTES(BUF_BYTES),
  .SCK_HALF (SCK_HALF),
  .CS_GAP   (CS_GAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi),
  .busy_q   (busy_q),
  .done_q   (done_q),
  .err_q    (err_q)
);

// File: tb/spi_menu_seq_tb.sv
module spi_menu_seq_tb;
  localparam int BB    = 16;
  localparam int HALF  = 1;
  localparam int GAP   = 2;
  localparam int AW    = 4;
  localparam int WORDS = BB / 4;
  localparam int MINGAP = 2 * 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  always #2 clk = ~clk;

  spi_menu_seq #(.BUF_BYTES(BB), .SCK_HALF(HALF), .CS_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_chk = 0, n_bad = 0, seed = 0, finished = 0;
  longint cyc = 0, rise_cyc = 0, gap_last = 0;
  int nfr = 0, sbit = 0, obit = 0, sclk_bad = 0;
  int flen [8];
  logic [7:0] fb [8][32];
  logic [7:0] sh = '0;
  logic [7:0] mbuf [BB];
  logic [7:0] cur_pat;

  assign cur_pat  = 8'(((obit / 8) * 29) + seed);
  assign spi_miso = cur_pat[3'(7 - (obit % 8))];

  function automatic logic [7:0] pat(int k);
    return 8'(k * 29 + seed);
  endfunction
  function automatic logic [7:0] op(int i);
    return 8'(8'h90 + i * 7);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && finished == 0) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  always @(negedge spi_cs_n) begin
    sbit = 0; obit = 0;
    if (spi_sclk) sclk_bad++;
    if (nfr > 0) gap_last = cyc - rise_cyc;
  end
  always @(posedge spi_cs_n) begin
    if (nfr < 8) flen[nfr] = sbit / 8;
    nfr++;
    rise_cyc = cyc;
    if (spi_sclk) sclk_bad++;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    sbit++;
    if (sbit % 8 == 0 && nfr < 8 && sbit / 8 <= 32) fb[nfr][sbit/8-1] = sh;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) obit++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic chk(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(1, s);
      if (!s[0]) break;
    end
  endtask
  task automatic check_buf(input string req);
    logic [31:0] d;
    for (int w = 0; w < WORDS; w++) begin
      rd(8 + w, d);
      for (int b = 0; b < 4; b++) chk(req, d[8*b +: 8], mbuf[4*w+b]);
    end
  endtask

  task automatic run(input int idx, input bit pen, input bit psel, input bit den, input int cnt);
    logic [31:0] s, w;
    int typ, m, off;
    for (int k = 0; k < WORDS; k++) begin
      for (int b = 0; b < 4; b++) begin
        mbuf[4*k+b] = 8'((4*k+b) * 13 + seed * 3);
        w[8*b +: 8] = mbuf[4*k+b];
      end
      wr(8 + k, w);
    end
    seed++;
    nfr = 0; sclk_bad = 0;
    wr(0, (32'(den) << 14) | (32'(cnt - 1) << 8) | (32'(idx) << 4) |
          (32'(pen) << 3) | (32'(psel) << 2) | 32'h2);
    wait_idle();
    typ = idx % 4;
    m = pen ? 1 : 0;
    off = (typ >= 2) ? 4 : 1;
    chk("R5 frames", nfr, m + 1);
    if (pen) begin
      chk("R5 prefix len", flen[0], 1);
      chk("R5 prefix op", fb[0][0], psel ? 8'h50 : 8'h06);
      check(gap_last >= MINGAP, "R6 gap", gap_last, MINGAP);
    end
    if (den) chk("R4 frame len", flen[m], off + cnt);
    else     chk("R10 frame len", flen[m], off);
    chk("R2 opcode", fb[m][0], op(idx));
    if (typ >= 2) begin
      chk("R3 addr hi", fb[m][1], 8'h12);
      chk("R3 addr mid", fb[m][2], 8'h34);
      chk("R3 addr lo", fb[m][3], 8'h56);
    end
    if (den && typ[0]) for (int j = 0; j < cnt; j++) chk("R4 wr data", fb[m][off+j], mbuf[j]);
    if (den && !typ[0]) for (int j = 0; j < cnt; j++) mbuf[j] = pat(off + j);
    check_buf("R4 buffer");
    chk("R7 sclk at cs edge", sclk_bad, 0);
    rd(1, s); chk("R8 done", s, 2);
    wr(1, 32'h2);
    rd(1, s); chk("R8 w1c", s, 0);
  endtask

  initial begin
    logic [31:0] d, lng;
    for (int i = 0; i < BB; i++) mbuf[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sclk", spi_sclk, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) begin rd(a, d); chk("R1 reg", d, 0); end
    check_buf("R1 buffer");

    wr(2, 32'hA5123456);
    rd(2, d); chk("R3 addr upper bits", d, 32'h00123456);
    wr(3, 32'h5006);
    wr(4, 32'hE4E4);
    wr(5, {op(3), op(2), op(1), op(0)});
    wr(6, {op(7), op(6), op(5), op(4)});
    rd(4, d); chk("R2 type reg", d, 32'hE4E4);

    for (int idx = 0; idx < 8; idx++)
      for (int den = 0; den < 2; den++)
        for (int pm = 0; pm < 3; pm++)
          run(idx, pm != 0, pm == 2, den[0], ((idx * 5 + pm * 3) % BB) + 1);
    for (int n = 1; n <= BB; n++) run(3, 1'b0, 1'b0, 1'b1, n);
    for (int n = 1; n <= BB; n++) run(2, 1'b1, 1'b1, 1'b1, n);
    for (int n = 1; n <= BB; n++) run(0, 1'b0, 1'b0, 1'b1, n);

    nfr = 0;
    lng = (32'h1 << 14) | (32'(BB - 1) << 8) | (32'h3 << 4) | 32'h2;
    wr(0, lng);
    repeat (5) @(negedge clk);
    wr(0, (32'h1 << 14) | (32'h5 << 4) | 32'h2);
    wr(5, 32'hDEADBEEF);
    wr(2, 32'h00FFFFFF);
    wait_idle();
    rd(1, d); chk("R9 err on busy start", d, 6);
    chk("R9 one frame", nfr, 1);
    chk("R9 frame intact", flen[0], 4 + BB);
    chk("R9 opcode intact", fb[0][0], op(3));
    rd(0, d); chk("R9 ctl unchanged", d, lng & 32'hFFFFFFFD);
    rd(5, d); chk("R9 menu unchanged", d, {op(3), op(2), op(1), op(0)});
    rd(2, d); chk("R9 addr unchanged", d, 32'h00123456);
    wr(1, 32'h6);
    rd(1, d); chk("R8 w1c both", d, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule